// File: doc/BRIEF.md
# Object Boundary Tracer with Grayscale Path Statistics

The block walks the outer contour of one object in a 128x128 window. A label memory marks which object each pixel belongs to, and a grayscale memory of the same size holds the pixel intensities. The host gives an object label, a start pixel on that object's edge and a one-cycle start pulse. The tracer then probes the 8-connected neighbourhood in counterclockwise order, using the Moore-neighbour rule. It steps from edge pixel to edge pixel and adds up the grayscale values it passes. Because the path statistics come out of the block directly, software never has to walk the contour.

When the walk closes, the block divides the running sums by the path length with one shared sequential divider. It then reports the path length, the mean intensity and the variance. A step cap stops contours that are too long and raises an overflow flag. Filling the two memories and labelling the objects happen elsewhere. The block only reads the memories, through two synchronous read ports.

Top module: `boundary_tracer`

## Requirements
- R1: After reset, `done` and `overflow` are low until a trace has finished.
- R2: Direction codes are 0=+x, 1=+x/-y, 2=-y, 3=-x/-y, 4=-x, 5=-x/+y, 6=+y and 7=+x/+y. The search at the start pixel begins at code 4. After a move in direction d, the next search begins at (d+6) mod 8, and each further probe adds 1 mod 8. Every move goes to one of the 8 neighbours of the current pixel.
- R3: A neighbour is part of the object only if its label equals `obj_label`. Pixels with label 0 or with any other label are background.
- R4: A neighbour outside the 128x128 window is treated as background.
- R5: The trace ends when the walk is back on the start pixel and the next move found has the same direction as the first move. `path_len` is the number of moves. Each pixel's gray value is accumulated once for every time the walk leaves that pixel.
- R6: A start pixel with no object neighbour gives `path_len` = 1, `mean` = its gray value and `variance` = 0.
- R7: `mean` = floor(S/N) and `variance` = floor(Q/N) - mean^2. Here N is the path length, S is the sum of the accumulated gray values and Q is the sum of their squares.
- R8: If MAX_STEPS moves have been made and another is needed, the trace stops with `overflow` high. `path_len` is then MAX_STEPS, and the statistics cover those MAX_STEPS pixels.
- R9: `done` stays high, with all results stable, until the next `start`. A `start` is accepted when the block is idle or done.
- R10: The memory address is y*128+x, with y in bits 13:7 and x in bits 6:0. Read data arrives on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a trace |
| obj_label | input | LBL_W | Label of the object to trace |
| start_x | input | 7 | Start pixel column |
| start_y | input | 7 | Start pixel row |
| lbl_addr | output | 14 | Label memory read address (neighbour being probed) |
| lbl_data | input | LBL_W | Label memory read data, one cycle after address |
| gray_addr | output | 14 | Grayscale memory read address (current pixel) |
| gray_data | input | PIX_W | Grayscale read data, one cycle after address |
| done | output | 1 | Results valid; held until next start |
| overflow | output | 1 | Trace hit the step cap (valid with done) |
| path_len | output | $clog2(MAX_STEPS+1) | Number of accumulated pixels |
| mean | output | PIX_W | Floor of mean gray value |
| variance | output | 2*PIX_W | Integer variance of gray values |

## Verification
The checker assumes three things about the inputs. The start pixel carries the chosen label. `start` is pulsed only while the block is idle or showing a result. Both memories answer with exactly one cycle of latency. The bench keeps to these rules: it models both memories as registered reads of a shape function, places every start pixel on the object it names, and pulses `start` only after `done` has been seen. The stimulus varies the shapes so that each search rule is used: single pixels, rectangles, objects cut by the window edges, diagonal lines, objects touching objects with other labels, and a full window that exceeds the step cap.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int COORD_W = 7;
    localparam int IMG_DIM = 1 << COORD_W;
    localparam int ADDR_W  = 2 * COORD_W;

    typedef logic [2:0] dir_t;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } coord_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROBE, ST_EVAL, ST_DM_GO, ST_DM_WAIT, ST_DV_GO, ST_DV_WAIT, ST_FIN
    } trc_state_t;

    localparam dir_t SEARCH_INIT = 3'd4;
    localparam dir_t BACKSTEP    = 3'd6;

    function automatic logic signed [1:0] dir_dx(dir_t d);
        case (d)
            3'd0, 3'd1, 3'd7: return 2'sd1;
            3'd3, 3'd4, 3'd5: return -2'sd1;
            default:          return 2'sd0;
        endcase
    endfunction

    function automatic logic signed [1:0] dir_dy(dir_t d);
        case (d)
            3'd1, 3'd2, 3'd3: return -2'sd1;
            3'd5, 3'd6, 3'd7: return 2'sd1;
            default:          return 2'sd0;
        endcase
    endfunction
endpackage

// File: rtl/trc_nbr.sv
module trc_nbr
    import trc_pkg::*;
(
    input  coord_t cur,
    input  dir_t   dir,
    output coord_t nxt,
    output logic   inb
);
    logic signed [1:0]         ddx, ddy;
    logic signed [COORD_W+1:0] px, py;

    always_comb begin
        ddx = dir_dx(dir);
        ddy = dir_dy(dir);
        px  = $signed({2'b00, cur.x}) + $signed({{COORD_W{ddx[1]}}, ddx});
        py  = $signed({2'b00, cur.y}) + $signed({{COORD_W{ddy[1]}}, ddy});
        // -1 sets the sign bit, IMG_DIM sets bit COORD_W
        inb   = !px[COORD_W+1] && !px[COORD_W] && !py[COORD_W+1] && !py[COORD_W];
        nxt.x = px[COORD_W-1:0];
        nxt.y = py[COORD_W-1:0];
    end
endmodule

// File: rtl/trc_acc.sv
module trc_acc #(
    parameter int PIX_W = 8,
    parameter int CW    = 11,
    localparam int SUM_W = PIX_W + CW,
    localparam int SQ_W  = 2 * PIX_W + CW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add,
    input  logic [PIX_W-1:0] pix,
    output logic [CW-1:0]    count,
    output logic [SUM_W-1:0] sum,
    output logic [SQ_W-1:0]  sumsq
);
    logic [2*PIX_W-1:0] sq;
    assign sq = (2*PIX_W)'(pix) * (2*PIX_W)'(pix);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            sum   <= '0;
            sumsq <= '0;
        end else if (add) begin
            count <= count + CW'(1);
            sum   <= sum + SUM_W'(pix);
            sumsq <= sumsq + SQ_W'(sq);
        end
    end
endmodule

// File: rtl/trc_div.sv
module trc_div #(
    parameter int NW = 27,
    parameter int DW = 11,
    localparam int CNT_W = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          valid,
    output logic [NW-1:0] quot
);
    logic [DW-1:0]    rem;
    logic [NW-1:0]    q;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DW:0]      trial, diff;
    logic             ge;

    always_comb begin
        trial = {rem, q[NW-1]};
        ge    = trial >= {1'b0, divisor};
        diff  = trial - {1'b0, divisor};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            valid <= 1'b0;
            rem   <= '0;
            q     <= '0;
            cnt   <= '0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                rem  <= '0;
                q    <= dividend;
                cnt  <= CNT_W'(NW);
                busy <= 1'b1;
            end else if (busy) begin
                rem <= ge ? diff[DW-1:0] : trial[DW-1:0];
                q   <= {q[NW-2:0], ge};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy  <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end

    assign quot = q;
endmodule

// File: rtl/boundary_tracer.sv
module boundary_tracer
    import trc_pkg::*;
#(
    parameter int LBL_W     = 8,
    parameter int PIX_W     = 8,
    parameter int MAX_STEPS = 1024,
    localparam int CW    = $clog2(MAX_STEPS + 1),
    localparam int SUM_W = PIX_W + CW,
    localparam int SQ_W  = 2 * PIX_W + CW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [LBL_W-1:0]   obj_label,
    input  logic [COORD_W-1:0] start_x,
    input  logic [COORD_W-1:0] start_y,
    output logic [ADDR_W-1:0]  lbl_addr,
    input  logic [LBL_W-1:0]   lbl_data,
    output logic [ADDR_W-1:0]  gray_addr,
    input  logic [PIX_W-1:0]   gray_data,
    output logic               done,
    output logic               overflow,
    output logic [CW-1:0]      path_len,
    output logic [PIX_W-1:0]   mean,
    output logic [2*PIX_W-1:0] variance
);
    trc_state_t       state;
    coord_t           cur, org, ncoord;
    dir_t             dir, first_dir;
    logic [2:0]       tries;
    logic             moved, inb_q, ninb, err;
    logic [LBL_W-1:0] lab_q;
    logic [PIX_W-1:0] mean_q;
    logic [2*PIX_W-1:0] var_q, msq;

    logic             hit, at_origin, cap, acc_add, acc_clr, accept;
    logic [CW-1:0]    cnt;
    logic [SUM_W-1:0] sum;
    logic [SQ_W-1:0]  sumsq;
    logic             div_start, div_valid;
    logic [SQ_W-1:0]  div_num, quot;

    trc_nbr nbr_i (.cur(cur), .dir(dir), .nxt(ncoord), .inb(ninb));

    always_comb begin
        accept    = start && (state == ST_IDLE || state == ST_FIN);
        hit       = inb_q && (lbl_data == lab_q);
        at_origin = moved && (cur == org) && (dir == first_dir);
        cap       = (cnt == CW'(MAX_STEPS));
        acc_add   = (state == ST_EVAL) &&
                    ((hit && !at_origin && !cap) || (!hit && tries == 3'd7));
        acc_clr   = accept;
        div_start = (state == ST_DM_GO) || (state == ST_DV_GO);
        div_num   = (state == ST_DM_GO) ? SQ_W'(sum) : sumsq;
        msq       = (2*PIX_W)'(mean_q) * (2*PIX_W)'(mean_q);
    end

    trc_acc #(.PIX_W(PIX_W), .CW(CW)) acc_i (
        .clk(clk), .rst(rst), .clr(acc_clr), .add(acc_add), .pix(gray_data),
        .count(cnt), .sum(sum), .sumsq(sumsq)
    );

    trc_div #(.NW(SQ_W), .DW(CW)) div_i (
        .clk(clk), .rst(rst), .start(div_start), .dividend(div_num),
        .divisor(cnt), .valid(div_valid), .quot(quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur       <= '0;
            org       <= '0;
            dir       <= SEARCH_INIT;
            first_dir <= '0;
            tries     <= '0;
            moved     <= 1'b0;
            inb_q     <= 1'b0;
            err       <= 1'b0;
            lab_q     <= '0;
            mean_q    <= '0;
            var_q     <= '0;
        end else if (accept) begin
            state <= ST_PROBE;
            cur   <= '{y: start_y, x: start_x};
            org   <= '{y: start_y, x: start_x};
            dir   <= SEARCH_INIT;
            tries <= '0;
            moved <= 1'b0;
            err   <= 1'b0;
            lab_q <= obj_label;
        end else begin
            case (state)
                ST_PROBE: begin
                    inb_q <= ninb;
                    state <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (hit) begin
                        if (at_origin) begin
                            state <= ST_DM_GO;
                        end else if (cap) begin
                            err   <= 1'b1;
                            state <= ST_DM_GO;
                        end else begin
                            cur   <= ncoord;
                            dir   <= dir + BACKSTEP;
                            tries <= '0;
                            moved <= 1'b1;
                            if (!moved) first_dir <= dir;
                            state <= ST_PROBE;
                        end
                    end else if (tries == 3'd7) begin
                        state <= ST_DM_GO;
                    end else begin
                        dir   <= dir + 3'd1;
                        tries <= tries + 3'd1;
                        state <= ST_PROBE;
                    end
                end
                ST_DM_GO:   state <= ST_DM_WAIT;
                ST_DM_WAIT: if (div_valid) begin
                    mean_q <= quot[PIX_W-1:0];
                    state  <= ST_DV_GO;
                end
                ST_DV_GO:   state <= ST_DV_WAIT;
                ST_DV_WAIT: if (div_valid) begin
                    var_q <= quot[2*PIX_W-1:0] - msq;
                    state <= ST_FIN;
                end
                default: ;
            endcase
        end
    end

    assign lbl_addr  = ncoord;
    assign gray_addr = cur;
    assign done      = (state == ST_FIN);
    assign overflow  = (state == ST_FIN) && err;
    assign path_len  = cnt;
    assign mean      = mean_q;
    assign variance  = var_q;
endmodule

// File: rtl/trc_chk.sv
module trc_chk
    import trc_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int MAX_STEPS = 1024,
    localparam int CW = $clog2(MAX_STEPS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic               overflow,
    input logic [CW-1:0]      path_len,
    input logic [PIX_W-1:0]   mean,
    input logic [2*PIX_W-1:0] variance,
    input logic [ADDR_W-1:0]  gray_addr
);
    logic [ADDR_W-1:0]  prev_addr;
    logic               prev_start;
    coord_t             pc, cc;
    logic [COORD_W-1:0] ax, ay;
    logic               step_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr  <= '0;
            prev_start <= 1'b0;
        end else begin
            prev_addr  <= gray_addr;
            prev_start <= start;
        end
    end

    always_comb begin
        pc      = prev_addr;
        cc      = gray_addr;
        ax      = (cc.x > pc.x) ? cc.x - pc.x : pc.x - cc.x;
        ay      = (cc.y > pc.y) ? cc.y - pc.y : pc.y - cc.y;
        step_ok = (ax <= COORD_W'(1)) && (ay <= COORD_W'(1));
    end

    // R2
    path_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!prev_start && gray_addr != prev_addr) |-> step_ok);

    // R8
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (path_len != '0 && path_len <= CW'(MAX_STEPS)));

    // R8
    overflow_len_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (done && path_len == CW'(MAX_STEPS)));

    // R6
    single_var_chk: assert property (@(posedge clk) disable iff (rst)
        (done && path_len == CW'(1)) |-> variance == '0);

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(path_len) && $stable(mean) &&
                              $stable(variance) && $stable(overflow)));
endmodule

bind boundary_tracer trc_chk #(.PIX_W(PIX_W), .MAX_STEPS(MAX_STEPS)) chk_i (
    .clk(clk), .rst(rst), .start(start), .done(done), .overflow(overflow),
    .path_len(path_len), .mean(mean), .variance(variance), .gray_addr(gray_addr)
);

// File: tb/boundary_tracer_tb_top.sv
module boundary_tracer_tb_top;
    localparam int MAXS = 200;
    localparam int CW   = $clog2(MAXS + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  obj_label = '0;
    logic [6:0]  start_x = '0, start_y = '0;
    logic [13:0] lbl_addr, gray_addr;
    logic [7:0]  lbl_data, gray_data;
    logic        done, overflow;
    logic [CW-1:0] path_len;
    logic [7:0]  mean;
    logic [15:0] variance;

    int n_chk = 0;
    int n_bad = 0;

    // shape description
    int kind = 0;
    int lab = 1, olab = 2, seed = 0;
    int rx0, ry0, rx1, ry1;
    int ox0 = -1, oy0 = -1, ox1 = -1, oy1 = -1;

    always #2 clk = ~clk;

    boundary_tracer #(.LBL_W(8), .PIX_W(8), .MAX_STEPS(MAXS)) dut_i (
        .clk(clk), .rst(rst), .start(start), .obj_label(obj_label),
        .start_x(start_x), .start_y(start_y), .lbl_addr(lbl_addr),
        .lbl_data(lbl_data), .gray_addr(gray_addr), .gray_data(gray_data),
        .done(done), .overflow(overflow), .path_len(path_len),
        .mean(mean), .variance(variance)
    );

    function automatic int lbl_at(int x, int y);
        if (kind == 1) return lab;
        if (kind == 2) return (x - y == rx0 && y >= ry0 && y <= ry1) ? lab : 0;
        if (x >= rx0 && x <= rx1 && y >= ry0 && y <= ry1) return lab;
        if (x >= ox0 && x <= ox1 && y >= oy0 && y <= oy1) return olab;
        return 0;
    endfunction

    function automatic int gray_at(int x, int y);
        return (x * 3 + y * 5 + seed) & 255;
    endfunction

    function automatic int ddx(int d);
        case (d)
            0, 1, 7: return 1;
            3, 4, 5: return -1;
            default: return 0;
        endcase
    endfunction

    function automatic int ddy(int d);
        case (d)
            1, 2, 3: return -1;
            5, 6, 7: return 1;
            default: return 0;
        endcase
    endfunction

    // R10: one-cycle registered reads, address = y*128 + x
    always @(posedge clk) begin
        lbl_data  <= 8'(lbl_at(int'(lbl_addr[6:0]), int'(lbl_addr[13:7])));
        gray_data <= 8'(gray_at(int'(gray_addr[6:0]), int'(gray_addr[13:7])));
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: actual hung, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic check_val(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Moore-neighbour walk per R2..R8
    task automatic model(input int sx, input int sy,
                         output int len, output int mn, output int vr, output int ov);
        int cx, cy, d, fd, nd, nx, ny, cnt, g;
        bit moved, found;
        longint sum, sq;
        cx = sx; cy = sy; d = 4; fd = 0; cnt = 0; moved = 0; sum = 0; sq = 0; ov = 0;
        nd = 0; nx = 0; ny = 0;
        while (1) begin
            found = 0;
            for (int t = 0; t < 8; t++) begin
                nd = (d + t) % 8;
                nx = cx + ddx(nd);
                ny = cy + ddy(nd);
                if (nx >= 0 && nx < 128 && ny >= 0 && ny < 128 && lbl_at(nx, ny) == lab) begin
                    found = 1;
                    break;
                end
            end
            if (!found) begin
                g = gray_at(cx, cy); cnt++; sum += g; sq += g * g;
                break;
            end
            if (moved && cx == sx && cy == sy && nd == fd) break;
            if (cnt == MAXS) begin ov = 1; break; end
            g = gray_at(cx, cy); cnt++; sum += g; sq += g * g;
            if (!moved) fd = nd;
            moved = 1;
            cx = nx; cy = ny;
            d = (nd + 6) % 8;
        end
        len = cnt;
        mn  = int'(sum / cnt);
        vr  = int'(sq / cnt) - mn * mn;
    endtask

    task automatic run_and_check(input string req, input int sx, input int sy);
        int el, em, ev, eo, guard;
        @(negedge clk);
        obj_label = 8'(lab);
        start_x = 7'(sx);
        start_y = 7'(sy);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        model(sx, sy, el, em, ev, eo);
        check_val({req, " done"}, int'(done), 1);
        check_val({req, " path_len"}, int'(path_len), el);
        check_val({req, " mean"}, int'(mean), em);
        check_val({req, " variance"}, int'(variance), ev);
        check_val({req, " overflow"}, int'(overflow), eo);
    endtask

    task automatic set_rect(input int x0, input int y0, input int x1, input int y1);
        kind = 0; rx0 = x0; ry0 = y0; rx1 = x1; ry1 = y1;
        ox0 = -1; oy0 = -1; ox1 = -1; oy1 = -1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_val("R1 done after reset", int'(done), 0);
        check_val("R1 overflow after reset", int'(overflow), 0);
    endtask

    task automatic t_single();
        set_rect(50, 60, 50, 60); seed = 17;
        run_and_check("R6 isolated pixel", 50, 60);
        check_val("R6 isolated length", int'(path_len), 1);
        check_val("R6 isolated variance", int'(variance), 0);
        check_val("R6 isolated mean", int'(mean), gray_at(50, 60));
    endtask

    task automatic t_rect();
        set_rect(10, 20, 14, 23); seed = 3;
        run_and_check("R5 rectangle", 10, 20);
        check_val("R5 rectangle moves", int'(path_len), 14);
    endtask

    task automatic t_corner();
        set_rect(0, 0, 3, 6); seed = 40;
        run_and_check("R4 top-left corner", 0, 0);
        set_rect(120, 100, 127, 127); seed = 90;
        run_and_check("R4 bottom-right edge", 120, 100);
    endtask

    task automatic t_line();
        set_rect(30, 30, 39, 30); seed = 200;
        run_and_check("R5 thin line", 30, 30);
        check_val("R5 thin line moves", int'(path_len), 18);
    endtask

    task automatic t_diag();
        kind = 2; rx0 = 5; ry0 = 40; ry1 = 47; seed = 77;
        run_and_check("R2 diagonal", 45, 40);
    endtask

    task automatic t_other_label();
        set_rect(60, 60, 65, 64); seed = 11;
        ox0 = 66; oy0 = 58; ox1 = 70; oy1 = 66; olab = 9;
        run_and_check("R3 touching other label", 60, 60);
        check_val("R3 other label ignored", int'(path_len), 18);
    endtask

    task automatic t_hold();
        int l0, m0, v0;
        set_rect(80, 10, 83, 12); seed = 250;
        run_and_check("R7 stats", 80, 10);
        l0 = int'(path_len); m0 = int'(mean); v0 = int'(variance);
        repeat (20) @(negedge clk);
        check_val("R9 done held", int'(done), 1);
        check_val("R9 length held", int'(path_len), l0);
        check_val("R9 mean held", int'(mean), m0);
        check_val("R9 variance held", int'(variance), v0);
        set_rect(90, 90, 92, 95); seed = 128;
        run_and_check("R9 restart from done", 90, 90);
    endtask

    task automatic t_overflow();
        kind = 1; seed = 5;
        run_and_check("R8 step cap", 0, 0);
        check_val("R8 overflow flag", int'(overflow), 1);
        check_val("R8 capped length", int'(path_len), MAXS);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_rect();
        t_corner();
        t_line();
        t_diag();
        t_other_label();
        t_hold();
        t_overflow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule